// File: doc/BRIEF.md
# Teletext Control Register Bank

This block is the register bank that sits behind a two-wire serial slave. A protocol engine in front of it decodes bus traffic into three kinds of strobe: a sub-address load, a byte write and a byte read. The bank keeps a register pointer that the sub-address sets and that every accepted byte moves on. Behind the pointer are eight write-only configuration registers (two mode registers, page-request address and data, display chapter, two display-control registers and display mode), three cursor registers holding a chapter, row and column, and one shared data address. A write to the data address stores the byte into page memory at the cursor. A read there returns either the memory byte at the cursor or a read-only status byte, chosen by bit 0 of mode register A.

Each access to page memory through the data address moves the cursor on by one column. After the last displayable column the cursor returns to column 0 of the next row. After reset a preset sequencer fills the whole page memory with the space code and writes the white-alphanumerics code into chapter 0, row 0, column 7. Host traffic is refused while that sequence runs. The memory array sits outside the block and is reached through a registered write/read port. A read answer appears three cycles after its strobe.

Top module: `ttx_ctrl_regbank`

## Requirements
- R1: While reset is held and on its release, every register output reads zero except show_norm and show_flash, which read 03h; preset_busy is 1.
- R2: After reset the block writes every memory address once, for 2^(CH_W+ROW_W+COL_W) cycles of preset_busy. Every byte is written as 20h except the address of chapter 0, row 0, column 7, which is written as 07h. preset_busy then drops.
- R3: Sub-address, write and read strobes that arrive while preset_busy is 1 change no register and cause no memory access or read answer.
- R4: Only defined bits are stored; reserved bits read back as 0. The stored masks are: address 0 D5h, 1 and 2 7Fh, 3 1Fh, 4 07h, 5 to 7 FFh. Addresses 8, 9 and 10 keep only the low CH_W, ROW_W and COL_W bits.
- R5: A sub-address strobe loads the pointer. Each accepted write or read raises the pointer by one while it is below 11; at 11 or above it stays. At addresses 12 to 15 writes change nothing and reads return 00h.
- R6: A write at address 11 always stores the byte into memory at the cursor, whatever the value of mode_a bit 0.
- R7: A read at address 11 with mode_a bit 0 at 0 returns the memory byte at the cursor.
- R8: A read at address 11 with mode_a bit 0 at 1 returns the status byte. Bit 0 is sync_good, bit 7 is field_60hz AND sync_good, and bits 6:1 are 0.
- R9: Each memory access through address 11 advances the cursor column by one. A column at or above NCOLS-1 goes to 0 and the row rises by one, wrapping at its width. Status reads leave the cursor alone.
- R10: Reads at addresses 0 to 10 return 00h. Every accepted read raises rd_done for one cycle with rd_byte, three clock edges after the strobe edge.
- R11: mem_addr is the concatenation {chapter, row, column} of the cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | 1 | Sub-address strobe |
| sub_addr | input | 4 | Sub-address value |
| wr_valid | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte to write |
| rd_valid | input | 1 | Byte read strobe |
| rd_byte | output | 8 | Read answer |
| rd_done | output | 1 | Read answer valid |
| sync_good | input | 1 | Composite sync quality good |
| field_60hz | input | 1 | Field rate is 60 Hz |
| preset_busy | output | 1 | Memory preset running |
| mode_a | output | 8 | Mode register A (address 0) |
| mode_b | output | 8 | Mode register B (address 1) |
| req_addr | output | 8 | Page-request address (address 2) |
| req_data | output | 8 | Page-request data (address 3) |
| show_chapter | output | 8 | Displayed chapter (address 4) |
| show_norm | output | 8 | Display control, normal (address 5) |
| show_flash | output | 8 | Display control, newsflash/subtitle (address 6) |
| show_mode | output | 8 | Display mode (address 7) |
| cur_chapter | output | CH_W | Cursor chapter (address 8) |
| cur_row | output | ROW_W | Cursor row (address 9) |
| cur_col | output | COL_W | Cursor column (address 10) |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | CH_W+ROW_W+COL_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |

## Verification
The hardest state to reach is a cursor sitting on the last column of the last row with a memory write arriving, so that column and row wrap together. The stimulus loads the cursor registers directly, with the row at its maximum and the column at NCOLS-1, and then writes at address 11. It does the same with a column above NCOLS-1. A second hard case is host traffic during the preset. The bench issues strobes in the first cycles after reset and confirms that neither the registers nor the freshly preset memory show any trace of them.

// File: rtl/ttx_regbank_pkg.sv
package ttx_regbank_pkg;
  localparam int          NCFG      = 8;
  localparam logic [3:0]  DATA_PORT = 4'd11;
  localparam logic [3:0]  CUR_CH    = 4'd8;
  localparam logic [3:0]  CUR_ROW   = 4'd9;
  localparam logic [3:0]  CUR_COL   = 4'd10;
  localparam logic [7:0]  SPACE_CODE = 8'h20;
  localparam logic [7:0]  WHITE_CODE = 8'h07;

  typedef enum logic {SRC_CONST = 1'b0, SRC_MEM = 1'b1} rd_src_e;

  function automatic logic [7:0] cfg_mask(input int idx);
    case (idx)
      0:       return 8'hD5;
      1, 2:    return 8'h7F;
      3:       return 8'h1F;
      4:       return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] cfg_reset(input int idx);
    return (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
  endfunction
endpackage

// File: rtl/ttx_preset_seq.sv
module ttx_preset_seq #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  import ttx_regbank_pkg::*;
  localparam logic [AW-1:0] LAST   = '1;
  localparam logic [AW-1:0] HOME_7 = AW'(7);

  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  assign wr_addr = cnt;
  assign wr_data = (cnt == HOME_7) ? WHITE_CODE : SPACE_CODE;
endmodule

// File: rtl/ttx_reg_ptr.sv
module ttx_reg_ptr (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       sub_valid,
  input  logic [3:0] sub_addr,
  input  logic       wr_valid,
  input  logic       rd_valid,
  output logic [3:0] ptr,
  output logic       wr_hit,
  output logic       rd_hit
);
  import ttx_regbank_pkg::*;

  assign wr_hit = enable && !sub_valid && wr_valid;
  assign rd_hit = enable && !sub_valid && !wr_valid && rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (enable && sub_valid) begin
      ptr <= sub_addr;
    end else if ((wr_hit || rd_hit) && ptr < DATA_PORT) begin
      ptr <= ptr + 4'd1;
    end
  end
endmodule

// File: rtl/ttx_cursor.sv
module ttx_cursor #(
  parameter int CH_W  = 3,
  parameter int ROW_W = 5,
  parameter int COL_W = 6,
  parameter int NCOLS = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_ch,
  input  logic             ld_row,
  input  logic             ld_col,
  input  logic [7:0]       din,
  input  logic             adv,
  output logic [CH_W-1:0]  ch,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NCOLS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ch  <= '0;
      row <= '0;
      col <= '0;
    end else begin
      if (ld_ch)  ch  <= din[CH_W-1:0];
      if (ld_row) row <= din[ROW_W-1:0];
      if (ld_col) col <= din[COL_W-1:0];
      if (adv) begin
        if (col >= LAST_COL) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ttx_ctrl_regbank.sv
module ttx_ctrl_regbank #(
  parameter int CH_W  = 3,
  parameter int ROW_W = 5,
  parameter int COL_W = 6,
  parameter int NCOLS = 40,
  localparam int AW   = CH_W + ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sub_valid,
  input  logic [3:0]       sub_addr,
  input  logic             wr_valid,
  input  logic [7:0]       wr_byte,
  input  logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             rd_done,
  input  logic             sync_good,
  input  logic             field_60hz,
  output logic             preset_busy,
  output logic [7:0]       mode_a,
  output logic [7:0]       mode_b,
  output logic [7:0]       req_addr,
  output logic [7:0]       req_data,
  output logic [7:0]       show_chapter,
  output logic [7:0]       show_norm,
  output logic [7:0]       show_flash,
  output logic [7:0]       show_mode,
  output logic [CH_W-1:0]  cur_chapter,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output logic             mem_we,
  output logic             mem_re,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata
);
  import ttx_regbank_pkg::*;

  logic          busy;
  logic [AW-1:0] pre_addr;
  logic [7:0]    pre_data;
  logic [3:0]    ptr;
  logic          wr_hit, rd_hit;
  logic          port_wr, port_rd, cur_adv;
  logic [7:0]    cfg [NCFG];
  logic [7:0]    status_byte;
  logic [7:0]    rd_val;

  ttx_preset_seq #(.AW(AW)) u_preset (
    .clk(clk), .rst(rst), .busy(busy), .wr_addr(pre_addr), .wr_data(pre_data)
  );

  ttx_reg_ptr u_ptr (
    .clk(clk), .rst(rst), .enable(!busy), .sub_valid(sub_valid),
    .sub_addr(sub_addr), .wr_valid(wr_valid), .rd_valid(rd_valid),
    .ptr(ptr), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  assign port_wr = wr_hit && (ptr == DATA_PORT);
  assign port_rd = rd_hit && (ptr == DATA_PORT) && !cfg[0][0];
  assign cur_adv = port_wr || port_rd;

  ttx_cursor #(.CH_W(CH_W), .ROW_W(ROW_W), .COL_W(COL_W), .NCOLS(NCOLS)) u_cursor (
    .clk(clk), .rst(rst),
    .ld_ch (wr_hit && ptr == CUR_CH),
    .ld_row(wr_hit && ptr == CUR_ROW),
    .ld_col(wr_hit && ptr == CUR_COL),
    .din(wr_byte), .adv(cur_adv),
    .ch(cur_chapter), .row(cur_row), .col(cur_col)
  );

  // write-only configuration registers, one lane per address
  for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)
        cfg[gi] <= cfg_reset(gi);
      else if (wr_hit && ptr == 4'(gi))
        cfg[gi] <= wr_byte & cfg_mask(gi);
    end
  end

  assign mode_a       = cfg[0];
  assign mode_b       = cfg[1];
  assign req_addr     = cfg[2];
  assign req_data     = cfg[3];
  assign show_chapter = cfg[4];
  assign show_norm    = cfg[5];
  assign show_flash   = cfg[6];
  assign show_mode    = cfg[7];
  assign preset_busy  = busy;

  // memory port: preset owns it while busy, host afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (busy) begin
      mem_we    <= 1'b1;
      mem_re    <= 1'b0;
      mem_addr  <= pre_addr;
      mem_wdata <= pre_data;
    end else begin
      mem_we    <= port_wr;
      mem_re    <= port_rd;
      mem_addr  <= {cur_chapter, cur_row, cur_col};
      mem_wdata <= wr_byte;
    end
  end

  // read answer pipeline: strobe, memory turn, output
  assign status_byte = {field_60hz & sync_good, 6'b0, sync_good};
  assign rd_val = (ptr == DATA_PORT && cfg[0][0]) ? status_byte : 8'h00;

  logic       s1_v, s2_v;
  rd_src_e    s1_src, s2_src;
  logic [7:0] s1_val, s2_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      s1_src  <= SRC_CONST;
      s2_src  <= SRC_CONST;
      s1_val  <= '0;
      s2_val  <= '0;
      rd_done <= 1'b0;
      rd_byte <= '0;
    end else begin
      s1_v    <= rd_hit;
      s1_src  <= port_rd ? SRC_MEM : SRC_CONST;
      s1_val  <= rd_val;
      s2_v    <= s1_v;
      s2_src  <= s1_src;
      s2_val  <= s1_val;
      rd_done <= s2_v;
      if (s2_v) rd_byte <= (s2_src == SRC_MEM) ? mem_rdata : s2_val;
    end
  end
endmodule

// File: rtl/ttx_ctrl_regbank_chk.sv
module ttx_ctrl_regbank_chk #(
  parameter int COL_W = 6,
  parameter int NCOLS = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             mem_we,
  input logic             mem_re,
  input logic             rd_valid,
  input logic             rd_done,
  input logic             adv,
  input logic [COL_W-1:0] cur_col
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NCOLS - 1);

  p_preset_write_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> mem_we);

  p_refuse_host_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> !mem_re);

  p_one_mem_op_r6: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_col_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && cur_col >= LAST_COL) |=> cur_col == '0);

  p_col_step_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && cur_col < LAST_COL) |=> cur_col == $past(cur_col) + 1'b1);

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(rd_valid, 3));
endmodule

bind ttx_ctrl_regbank ttx_ctrl_regbank_chk #(.COL_W(COL_W), .NCOLS(NCOLS)) u_chk (
  .clk(clk), .rst(rst), .busy(preset_busy), .mem_we(mem_we), .mem_re(mem_re),
  .rd_valid(rd_valid), .rd_done(rd_done), .adv(cur_adv), .cur_col(cur_col)
);

// File: tb/ttx_ctrl_regbank_bench.sv
module ttx_ctrl_regbank_bench;
  localparam int CH_W = 2, ROW_W = 3, COL_W = 6, NCOLS = 40;
  localparam int AW = CH_W + ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic sub_valid = 0, wr_valid = 0, rd_valid = 0;
  logic [3:0] sub_addr = '0;
  logic [7:0] wr_byte = '0;
  logic sync_good = 0, field_60hz = 0;
  logic [7:0] rd_byte, mode_a, mode_b, req_addr, req_data;
  logic [7:0] show_chapter, show_norm, show_flash, show_mode;
  logic rd_done, preset_busy, mem_we, mem_re;
  logic [CH_W-1:0] cur_chapter;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [DEPTH];
  int checks = 0, fails = 0, we_count = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ttx_ctrl_regbank #(.CH_W(CH_W), .ROW_W(ROW_W), .COL_W(COL_W), .NCOLS(NCOLS)) u_ttx_ctrl_regbank (
    .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_addr(sub_addr),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .rd_done(rd_done), .sync_good(sync_good),
    .field_60hz(field_60hz), .preset_busy(preset_busy), .mode_a(mode_a),
    .mode_b(mode_b), .req_addr(req_addr), .req_data(req_data),
    .show_chapter(show_chapter), .show_norm(show_norm), .show_flash(show_flash),
    .show_mode(show_mode), .cur_chapter(cur_chapter), .cur_row(cur_row),
    .cur_col(cur_col), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'hEE;
  initial mem_rdata = '0;
  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr] <= mem_wdata; we_count <= we_count + 1; end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_sub(input int a);
    sub_valid = 1; sub_addr = 4'(a);
    @(posedge clk); #1 sub_valid = 0;
  endtask

  task automatic do_wr(input int v);
    wr_valid = 1; wr_byte = 8'(v);
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic do_rd(output logic [7:0] v, output logic ok);
    rd_valid = 1;
    @(posedge clk); #1 rd_valid = 0;
    @(posedge clk);
    @(posedge clk); #1;
    ok = rd_done; v = rd_byte;
  endtask

  function automatic int mask_of(input int a);
    case (a)
      0: return 'hD5;
      1, 2: return 'h7F;
      3: return 'h1F;
      4: return 'h07;
      8: return (1 << CH_W) - 1;
      9: return (1 << ROW_W) - 1;
      10: return (1 << COL_W) - 1;
      default: return 'hFF;
    endcase
  endfunction

  function automatic int out_of(input int a);
    case (a)
      0: return mode_a;        1: return mode_b;
      2: return req_addr;      3: return req_data;
      4: return show_chapter;  5: return show_norm;
      6: return show_flash;    7: return show_mode;
      8: return int'(cur_chapter);
      9: return int'(cur_row);
      default: return int'(cur_col);
    endcase
  endfunction

  function automatic int idx(input int c, input int r, input int k);
    return (c << (ROW_W + COL_W)) | (r << COL_W) | k;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v; logic ok; int n, bad, we0;
    repeat (3) @(posedge clk);
    #1;
    // R1: values under reset
    for (int a = 0; a < 11; a++)
      chk(out_of(a) == ((a == 5 || a == 6) ? 3 : 0), "R1 reset value", out_of(a), (a == 5 || a == 6) ? 3 : 0);
    chk(preset_busy == 1, "R1 busy in reset", preset_busy, 1);
    rst = 0;
    // R3: host traffic during preset is refused
    do_sub(0); do_wr('hFF); do_sub(11); do_wr('h99);
    n = 4;
    while (preset_busy && n < 100000) begin @(posedge clk); #1; n++; end
    chk(n == DEPTH, "R2 preset length", n, DEPTH);
    repeat (4) @(posedge clk); #1;
    chk(mode_a == 0, "R3 write during preset ignored", mode_a, 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != ((i == 7) ? 8'h07 : 8'h20)) bad++;
    chk(bad == 0, "R2 preset content", bad, 0);
    chk(mem[idx(0, 0, 7)] == 8'h07 && mem[idx(0, 0, 8)] == 8'h20, "R2 home byte", mem[7], 7);

    // R4: sweep every value into every register
    for (int a = 0; a < 11; a++)
      for (int b = 0; b < 256; b++) begin
        do_sub(a); do_wr(b); #1;
        chk(out_of(a) == (b & mask_of(a)), "R4 masked store", out_of(a), b & mask_of(a));
      end

    // R5: auto-increment across all registers, then into the data port
    begin
      int vals [11] = '{'h40, 'h11, 'h22, 'h33, 'h44, 'h55, 'h66, 'h77, 1, 2, 38};
      do_sub(0);
      for (int a = 0; a < 11; a++) do_wr(vals[a]);
      for (int a = 0; a < 11; a++)
        chk(out_of(a) == (vals[a] & mask_of(a)), "R5 auto-increment", out_of(a), vals[a] & mask_of(a));
    end
    do_wr('hAA); do_wr('hBB); do_wr('hCC);
    @(posedge clk); @(posedge clk); #1;
    chk(mem[idx(1, 2, 38)] == 8'hAA, "R6 R11 write at cursor", mem[idx(1, 2, 38)], 'hAA);
    chk(mem[idx(1, 2, 39)] == 8'hBB, "R9 column step", mem[idx(1, 2, 39)], 'hBB);
    chk(mem[idx(1, 3, 0)] == 8'hCC, "R9 column wrap to next row", mem[idx(1, 3, 0)], 'hCC);
    chk(cur_row == 3 && cur_col == 1, "R9 cursor after wrap", {cur_row, cur_col}, {3'd3, 6'd1});

    // R7: memory read back through the data port
    do_sub(8); do_wr(1); do_wr(2); do_wr(38);
    do_rd(v, ok); chk(ok && v == 8'hAA, "R7 read memory", v, 'hAA);
    do_rd(v, ok); chk(ok && v == 8'hBB, "R7 read next", v, 'hBB);
    do_rd(v, ok); chk(ok && v == 8'hCC, "R7 R10 read after wrap", v, 'hCC);
    chk(cur_row == 3 && cur_col == 1, "R9 reads advance cursor", {cur_row, cur_col}, {3'd3, 6'd1});

    // R6: write with status select still goes to memory; R8 status reads
    do_sub(0); do_wr(1);
    do_sub(11); do_wr('h5A);
    @(posedge clk); @(posedge clk); #1;
    chk(mem[idx(1, 3, 1)] == 8'h5A, "R6 write ignores select", mem[idx(1, 3, 1)], 'h5A);
    for (int s = 0; s < 4; s++) begin
      sync_good = s[0]; field_60hz = s[1];
      do_rd(v, ok);
      chk(ok && v == {s[1] & s[0], 6'b0, s[0]}, "R8 status byte", v, {s[1] & s[0], 6'b0, s[0]});
    end
    chk(cur_col == 2, "R9 status reads keep cursor", cur_col, 2);
    do_sub(0); do_wr(0);
    do_sub(8); do_wr(1); do_wr(3); do_wr(1);
    do_rd(v, ok); chk(ok && v == 8'h5A, "R7 read stored byte", v, 'h5A);

    // R10: write-only registers read as zero and the pointer steps
    do_sub(0);
    bad = 0;
    for (int a = 0; a < 11; a++) begin do_rd(v, ok); if (!ok || v != 0) bad++; end
    chk(bad == 0, "R10 write-only reads zero", bad, 0);
    do_rd(v, ok); chk(ok && v == 8'h20, "R5 pointer reached data port", v, 'h20);

    // R9: row and column wrap together, and a column beyond the last one
    do_sub(8); do_wr(3); do_wr(7); do_wr(39); do_wr('h77);
    #1; chk(cur_row == 0 && cur_col == 0, "R9 row wrap", {cur_row, cur_col}, 0);
    do_sub(10); do_wr(50); do_wr('h66);
    @(posedge clk); @(posedge clk); #1;
    chk(mem[idx(3, 7, 39)] == 8'h77 && mem[idx(3, 0, 50)] == 8'h66, "R9 R11 wrap writes", mem[idx(3, 0, 50)], 'h66);
    chk(cur_row == 1 && cur_col == 0, "R9 over-range column", {cur_row, cur_col}, {3'd1, 6'd0});

    // R5: addresses 12 to 15 change nothing
    we0 = we_count;
    for (int a = 12; a < 16; a++) begin
      do_sub(a); do_wr('hFF);
      do_rd(v, ok); chk(ok && v == 0, "R5 unused address reads zero", v, 0);
    end
    chk(we_count == we0 && mode_a == 0 && cur_col == 0, "R5 unused address write ignored", we_count - we0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule